// File: doc/BRIEF.md
# Byte Stream to Flit Framer and Deframer

This block packs a byte stream of known total length into 64-byte flits for an accelerator port, and unpacks such flits back into bytes. A message opens with a one-cycle start pulse carrying its byte count. The bytes then arrive one per handshake on a valid/ready input. Each flit carries a 512-bit payload, a final-flit marker and a 7-bit tail count. The tail count gives the number of valid bytes in the final flit, so messages of any length are supported.

The unpacking half takes flits on a valid/ready input. It releases the meaningful bytes in order on a byte-wide valid/ready output. When the final byte of a message has gone out, it raises a one-cycle done pulse. The two halves are independent and can run at the same time.

Top module: `flit_framer`

## Requirements
- R1: Message byte i is carried in flit i/64, at payload bits [8*(i mod 64)+7 : 8*(i mod 64)].
- R2: The final-flit marker (`fo_eop`) is 1 on the last flit of a message and 0 on every flit before it.
- R3: On the final flit, `fo_len` equals the total length mod 64. It equals 64 when the total length is a non-zero multiple of 64.
- R4: Payload bytes of the final flit at positions at or above `fo_len` are zero.
- R5: A start with length 0 produces exactly one flit, with `fo_eop`=1, `fo_len`=0 and an all-zero payload.
- R6: While `fo_valid` is 1 and `fo_ready` is 0, the outgoing flit (payload, marker and tail count) does not change, and `fo_valid` stays 1.
- R7: A start pulse that arrives before the current message's final flit has been transferred has no effect on the flits produced.
- R8: The deframer releases, in order, 64 bytes from each non-final flit, then the first `fi_len` bytes of the final flit. Any later bytes are never released.
- R9: `ob_done` is 1 for exactly the one cycle after the last byte of a final flit is transferred. For a final flit with `fi_len`=0, it is 1 in the cycle after that flit is accepted.
- R10: The deframer ignores `fi_len` on flits whose `fi_eop` is 0.
- R11: While `ob_valid` is 1 and `ob_ready` is 0, `ob_byte` does not change, and `ob_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_start | input | 1 | One-cycle pulse that opens a message |
| msg_bytes | input | CNT_W | Total byte count of the message, sampled with `msg_start` |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Framer accepts an input byte |
| in_byte | input | 8 | Input byte |
| fo_valid | output | 1 | Outgoing flit valid |
| fo_ready | input | 1 | Downstream accepts the flit |
| fo_payload | output | 512 | Outgoing flit payload, byte 0 in the low bits |
| fo_eop | output | 1 | Final flit of the message |
| fo_len | output | 7 | Valid bytes in the final flit |
| fi_valid | input | 1 | Incoming flit valid |
| fi_ready | output | 1 | Deframer accepts a flit |
| fi_payload | input | 512 | Incoming flit payload |
| fi_eop | input | 1 | Incoming flit is the final one |
| fi_len | input | 7 | Valid bytes in the incoming final flit |
| ob_valid | output | 1 | Output byte valid |
| ob_ready | input | 1 | Downstream accepts the byte |
| ob_byte | output | 8 | Output byte |
| ob_done | output | 1 | One-cycle pulse at the end of a message |

## Verification
Several properties are checked on every cycle:
- a held flit and a held byte stay stable under backpressure;
- the tail count of a final flit never exceeds 64;
- a non-final flit always leaves bytes still to come;
- a zero-length start produces the empty final flit;
- no byte is offered while the done pulse is high.

Other behaviour needs the scenarios. These are byte placement and ordering over a sweep of every length from 0 to 140, zero padding of the tail, and the tail count at each multiple of 64. They also cover a start pulse injected mid-message, junk tail counts on non-final flits, and junk bytes past the tail. Only the scenarios show the exact cycle of the done pulse.

// File: rtl/flit_pkg.sv
package flit_pkg;
    localparam int FLIT_BYTES = 64;
    localparam int FLIT_BITS  = FLIT_BYTES * 8;
    localparam int LEN_W      = $clog2(FLIT_BYTES + 1);
    localparam int IDX_W      = $clog2(FLIT_BYTES);

    typedef struct packed {
        logic [FLIT_BITS-1:0] payload;
        logic                 eop;
        logic [LEN_W-1:0]     len;
    } flit_t;

    // Number of bytes a flit contributes to the byte stream.
    function automatic logic [LEN_W-1:0] bytes_in_flit(input flit_t f);
        if (!f.eop)
            return LEN_W'(FLIT_BYTES);
        else if (f.len > LEN_W'(FLIT_BYTES))
            return LEN_W'(FLIT_BYTES);
        else
            return f.len;
    endfunction
endpackage

// File: rtl/flit_packer.sv
module flit_packer
    import flit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] total,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_byte,
    output logic             out_valid,
    input  logic             out_ready,
    output flit_t            out_flit
);
    logic                 busy;
    logic [CNT_W-1:0]     remaining;
    logic [IDX_W-1:0]     slot;
    logic [FLIT_BITS-1:0] acc;
    logic                 ov;
    logic                 oeop;
    logic [LEN_W-1:0]     olen;

    assign in_ready  = busy && !ov && (remaining != '0);
    assign out_valid = ov;
    assign out_flit  = '{payload: acc, eop: oeop, len: olen};

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            remaining <= '0;
            slot      <= '0;
            acc       <= '0;
            ov        <= 1'b0;
            oeop      <= 1'b0;
            olen      <= '0;
        end else begin
            if (ov && out_ready) begin
                ov  <= 1'b0;
                acc <= '0;
                if (oeop)
                    busy <= 1'b0;
            end
            if (!busy && start) begin
                busy      <= 1'b1;
                slot      <= '0;
                acc       <= '0;
                remaining <= total;
                if (total == '0) begin
                    ov   <= 1'b1;
                    oeop <= 1'b1;
                    olen <= '0;
                end
            end else if (in_valid && in_ready) begin
                acc[slot*8 +: 8] <= in_byte;
                remaining        <= remaining - 1'b1;
                if (slot == IDX_W'(FLIT_BYTES - 1) || remaining == CNT_W'(1)) begin
                    ov   <= 1'b1;
                    oeop <= (remaining == CNT_W'(1));
                    olen <= (remaining == CNT_W'(1)) ? LEN_W'(slot) + LEN_W'(1)
                                                     : LEN_W'(FLIT_BYTES);
                    slot <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end
        end
    end

    // R6: held flit does not move under backpressure
    assert_flit_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (ov && !out_ready) |=> (ov && $stable(acc) && $stable(oeop) && $stable(olen)));

    // R3: tail count of a final flit stays within one flit
    assert_tail_range_R3: assert property (@(posedge clk) disable iff (rst)
        (ov && oeop) |-> (olen <= LEN_W'(FLIT_BYTES)));

    // R2: a non-final flit always leaves bytes still to come
    assert_mid_flit_R2: assert property (@(posedge clk) disable iff (rst)
        (ov && !oeop) |-> (remaining != '0));

    // R5: empty message yields an empty final flit
    assert_empty_msg_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && total == '0) |=> (ov && oeop && olen == '0 && acc == '0));
endmodule

// File: rtl/flit_unpacker.sv
module flit_unpacker
    import flit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    output logic       in_ready,
    input  flit_t      in_flit,
    output logic       out_valid,
    input  logic       out_ready,
    output logic [7:0] out_byte,
    output logic       done
);
    logic                 held;
    logic [FLIT_BITS-1:0] hpay;
    logic [LEN_W-1:0]     hcnt;
    logic [LEN_W-1:0]     hpos;
    logic                 hlast;
    logic                 done_q;
    logic [LEN_W-1:0]     new_cnt;
    logic [IDX_W-1:0]     pick;

    assign new_cnt   = bytes_in_flit(in_flit);
    assign pick      = hpos[IDX_W-1:0];
    assign in_ready  = !held;
    assign out_valid = held;
    assign out_byte  = hpay[pick*8 +: 8];
    assign done      = done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            held   <= 1'b0;
            hpay   <= '0;
            hcnt   <= '0;
            hpos   <= '0;
            hlast  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (in_valid && !held) begin
                hpay  <= in_flit.payload;
                hcnt  <= new_cnt;
                hpos  <= '0;
                hlast <= in_flit.eop;
                if (new_cnt == '0)
                    done_q <= 1'b1;
                else
                    held <= 1'b1;
            end else if (held && out_ready) begin
                hpos <= hpos + 1'b1;
                if (hpos + LEN_W'(1) == hcnt) begin
                    held   <= 1'b0;
                    done_q <= hlast;
                end
            end
        end
    end

    // R11: offered byte is held under backpressure
    assert_byte_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (held && !out_ready) |=> (held && $stable(out_byte)));

    // R9: done never coincides with an offered byte
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !held);
endmodule

// File: rtl/flit_framer.sv
module flit_framer
    import flit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 msg_start,
    input  logic [CNT_W-1:0]     msg_bytes,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [7:0]           in_byte,
    output logic                 fo_valid,
    input  logic                 fo_ready,
    output logic [FLIT_BITS-1:0] fo_payload,
    output logic                 fo_eop,
    output logic [LEN_W-1:0]     fo_len,
    input  logic                 fi_valid,
    output logic                 fi_ready,
    input  logic [FLIT_BITS-1:0] fi_payload,
    input  logic                 fi_eop,
    input  logic [LEN_W-1:0]     fi_len,
    output logic                 ob_valid,
    input  logic                 ob_ready,
    output logic [7:0]           ob_byte,
    output logic                 ob_done
);
    flit_t tx_flit;
    flit_t rx_flit;

    assign fo_payload = tx_flit.payload;
    assign fo_eop     = tx_flit.eop;
    assign fo_len     = tx_flit.len;
    assign rx_flit    = '{payload: fi_payload, eop: fi_eop, len: fi_len};

    flit_packer #(.CNT_W(CNT_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .start    (msg_start),
        .total    (msg_bytes),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .in_byte  (in_byte),
        .out_valid(fo_valid),
        .out_ready(fo_ready),
        .out_flit (tx_flit)
    );

    flit_unpacker u_unpack (
        .clk      (clk),
        .rst      (rst),
        .in_valid (fi_valid),
        .in_ready (fi_ready),
        .in_flit  (rx_flit),
        .out_valid(ob_valid),
        .out_ready(ob_ready),
        .out_byte (ob_byte),
        .done     (ob_done)
    );
endmodule

// File: tb/flit_framer_tb.sv
module flit_framer_tb;
    localparam int CNT_W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         msg_start = 1'b0;
    logic [15:0]  msg_bytes = '0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [7:0]   in_byte = '0;
    logic         fo_valid;
    logic         fo_ready = 1'b0;
    logic [511:0] fo_payload;
    logic         fo_eop;
    logic [6:0]   fo_len;
    logic         fi_valid = 1'b0;
    logic         fi_ready;
    logic [511:0] fi_payload = '0;
    logic         fi_eop = 1'b0;
    logic [6:0]   fi_len = '0;
    logic         ob_valid;
    logic         ob_ready = 1'b0;
    logic [7:0]   ob_byte;
    logic         ob_done;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    flit_framer #(.CNT_W(CNT_W)) u_dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int m, input int i);
        return 8'((m * 31 + i * 7 + 1) & 255);
    endfunction

    function automatic logic [6:0] tail(input int n);
        if (n == 0) return 7'd0;
        if (n % 64 == 0) return 7'd64;
        return 7'(n % 64);
    endfunction

    task automatic run_frame(input int n, input int mode);
        int k = (n == 0) ? 1 : (n + 63) / 64;
        @(negedge clk);
        msg_start = 1'b1;
        msg_bytes = 16'(n);
        @(negedge clk);
        msg_start = 1'b0;
        fork
            begin : producer
                int i = 0;
                bit poked = 0;
                while (i < n) begin
                    @(negedge clk);
                    msg_start = (i == 2 && n > 10 && !poked);
                    if (msg_start) begin
                        msg_bytes = 16'd5;
                        poked = 1;
                    end
                    in_valid = 1'b1;
                    in_byte  = pat(n, i);
                    if (in_ready) i++;
                end
                @(negedge clk);
                in_valid  = 1'b0;
                msg_start = 1'b0;
            end
            begin : consumer
                int f = 0;
                bit was_held = 0;
                logic [511:0] saved = '0;
                while (f < k) begin
                    @(negedge clk);
                    if (was_held)
                        chk(fo_valid && fo_payload == saved, "R6", fo_payload, saved);
                    fo_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
                    was_held = fo_valid && !fo_ready;
                    saved = fo_payload;
                    if (fo_valid && fo_ready) begin
                        logic [511:0] e = '0;
                        bit last = (f == k - 1);
                        for (int b = 0; b < 64; b++)
                            if (64 * f + b < n) e[b*8 +: 8] = pat(n, 64 * f + b);
                        chk(fo_payload == e,
                            (n == 0) ? "R5" : (last && n % 64 != 0) ? "R4" : (n > 10) ? "R7" : "R1",
                            fo_payload, e);
                        chk(fo_eop == last, "R2", 512'(fo_eop), 512'(last));
                        if (last)
                            chk(fo_len == tail(n), (n == 0) ? "R5" : "R3", 512'(fo_len), 512'(tail(n)));
                        f++;
                    end
                end
                @(negedge clk);
                fo_ready = 1'b0;
            end
        join
    endtask

    task automatic run_deframe(input int n, input int mode);
        int k = (n == 0) ? 1 : (n + 63) / 64;
        fork
            begin : driver
                for (int f = 0; f < k; f++) begin
                    logic [511:0] p = '0;
                    bit last = (f == k - 1);
                    for (int b = 0; b < 64; b++)
                        p[b*8 +: 8] = (64 * f + b < n) ? pat(n + 300, 64 * f + b) : 8'hAA;
                    forever begin
                        @(negedge clk);
                        fi_valid   = 1'b1;
                        fi_payload = p;
                        fi_eop     = last;
                        fi_len     = last ? tail(n) : 7'd5;
                        if (fi_ready) break;
                    end
                end
                @(negedge clk);
                fi_valid = 1'b0;
            end
            begin : consumer
                if (n == 0) begin
                    bit seen = 0;
                    for (int w = 0; w < 20 && !seen; w++) begin
                        @(negedge clk);
                        if (ob_done) seen = 1;
                    end
                    chk(seen, "R9", 512'(seen), 512'(1));
                    @(negedge clk);
                    chk(!ob_done, "R9", 512'(ob_done), 512'(0));
                end else begin
                    int j = 0;
                    bit was_held = 0;
                    logic [7:0] saved = '0;
                    while (j < n) begin
                        @(negedge clk);
                        if (was_held)
                            chk(ob_valid && ob_byte == saved, "R11", 512'(ob_byte), 512'(saved));
                        ob_ready = (mode == 0) ? 1'b1 : ((cyc % 4) != 0);
                        was_held = ob_valid && !ob_ready;
                        saved = ob_byte;
                        if (ob_valid && ob_ready) begin
                            chk(ob_byte == pat(n + 300, j), (j < 64 * (k - 1)) ? "R10" : "R8",
                                512'(ob_byte), 512'(pat(n + 300, j)));
                            j++;
                        end
                    end
                    @(negedge clk);
                    ob_ready = 1'b0;
                    chk(ob_done && !ob_valid, "R9", 512'(ob_done), 512'(1));
                    @(negedge clk);
                    chk(!ob_done && !ob_valid, "R8", 512'({ob_done, ob_valid}), 512'(0));
                end
            end
        join
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!fo_valid && !in_ready, "R2", 512'({fo_valid, in_ready}), 512'(0));
        chk(!ob_valid && !ob_done && fi_ready, "R9", 512'({ob_valid, ob_done, fi_ready}), 512'(1));

        for (int n = 0; n <= 140; n++)
            run_frame(n, n % 2);
        run_frame(192, 1);
        run_frame(0, 0);

        for (int n = 0; n <= 140; n++)
            run_deframe(n, n % 2);
        run_deframe(128, 1);
        run_deframe(0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule